// File: doc/BRIEF.md
# I2C Master Data Byte Buffer

This block is the small byte queue that sits between the register-mapped host side of an I2C master controller and its transfer engine. On a write to the data register the host pushes a byte to be transmitted. On a read of the data register it pops a byte that was received. When the engine finishes a receive transfer of one to four bytes, it deposits all of them in a single cycle. The block keeps two status flags for the controller's status register: "buffer has data" and "buffer full".

The buffer holds DEPTH bytes (four by default). A read of an empty buffer returns a fixed pattern (0xFF). A write to a full buffer is dropped without any indication. Each read takes the oldest entry and moves the others down one place. A flush command from the mode register empties the buffer and clears both flags in the same cycle. The controller reset (rst_n, active low, asynchronous) does the same and also zeroes the storage.

A three-state machine (ST_EMPTY, ST_PART, ST_FULL) tracks occupancy. It decodes one operation per cycle in this priority order: OP_LOAD (engine load), OP_FLUSH, OP_PUSH (host write with room available), OP_POP (host read with data available), OP_IDLE. The transitions are as follows. OP_LOAD moves any state to ST_FULL when N equals DEPTH and to ST_PART otherwise. OP_FLUSH moves any state to ST_EMPTY. OP_PUSH moves ST_EMPTY or ST_PART to ST_PART, or to ST_FULL when the push fills the last slot. OP_POP moves ST_FULL to ST_PART, and moves ST_PART to ST_EMPTY when it takes the last byte. has_data is high in ST_PART and ST_FULL. full is high only in ST_FULL.

Top module: `i2c_mdata_buffer`

## Requirements
- R1: After reset, has_data and full are 0 and rd_data shows 0xFF.
- R2: Bytes pushed with wr_stb are returned by successive rd_stb reads in the order they were written.
- R3: A wr_stb while full is high is dropped: full stays 1, and the next reads return only the four earlier bytes.
- R4: Flags change on the clock edge that samples the strobe. The first push into an empty buffer sets has_data, and the push that fills the buffer sets full. full is never 1 while has_data is 0.
- R5: While the buffer is empty, rd_data is 0xFF. A rd_stb then changes no state, so a later push and read return the pushed byte.
- R6: rd_data combinationally shows the oldest byte. A rd_stb removes that byte and the next byte becomes the oldest. A read from a full buffer clears full, and a read of the last byte clears has_data.
- R7: flush empties the buffer and clears both flags on the next edge, and wins over a host write in the same cycle. Afterwards rd_data is 0xFF.
- R8: load_stb with load_count = N (binary, 1 to DEPTH) replaces the contents with N bytes. Byte i is taken from load_data[8i+7:8i] and byte 0 is read first. has_data is set, and full is set only when N equals DEPTH.
- R9: When load_stb coincides with wr_stb, rd_stb or flush, only the load takes effect.
- R10: load_stb with load_count of 0 or above DEPTH is ignored: flags and contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, active low |
| wr_stb | input | 1 | Host write of the data register |
| wr_data | input | WIDTH | Byte written by the host |
| rd_stb | input | 1 | Host read of the data register |
| rd_data | output | WIDTH | Oldest byte, or 0xFF when empty |
| flush | input | 1 | Flush command from the mode register |
| load_stb | input | 1 | Engine finished a receive transfer |
| load_count | input | $clog2(DEPTH+1) | Number of bytes received (N) |
| load_data | input | DEPTH*WIDTH | Received bytes, byte i at bits [8i+7:8i] |
| has_data | output | 1 | Buffer holds at least one byte |
| full | output | 1 | Buffer holds DEPTH bytes |

## Verification
The assertions check on every cycle that the flags stay consistent with each other and with the empty pattern on rd_data. They also check that a flush clears both flags, that a push into a full buffer leaves the flags and the head byte untouched, and that a valid load leaves the received byte 0 at the head with the flags set for its size. Only the bench scenarios can show that whole byte sequences come back in first-in order. The same holds for the effect of a load colliding with a host write, for a dropped fifth byte never appearing in later reads, and for the order in which a loaded burst is read back.

// File: rtl/i2c_mdata_buffer_pkg.sv
package i2c_mdata_buffer_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PART,
        ST_FULL
    } buf_state_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_FLUSH,
        OP_PUSH,
        OP_POP
    } buf_op_e;
endpackage

// File: rtl/i2c_mdata_buffer_ctrl.sv
module i2c_mdata_buffer_ctrl
    import i2c_mdata_buffer_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic            flush,
    input  logic            load_stb,
    input  logic [CNTW-1:0] load_count,
    output buf_op_e         op,
    output logic [CNTW-1:0] count,
    output logic            has_data,
    output logic            full
);
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(DEPTH);

    buf_state_e      state, state_nxt;
    logic [CNTW-1:0] count_nxt;
    logic            load_ok;
    buf_state_e      load_target;

    assign load_ok     = load_stb && (load_count != '0) && (load_count <= CNT_MAX);
    assign load_target = (load_count == CNT_MAX) ? ST_FULL : ST_PART;

    // operation decode, fixed priority
    always_comb begin
        if (load_ok)                        op = OP_LOAD;
        else if (flush)                     op = OP_FLUSH;
        else if (wr_stb && count < CNT_MAX) op = OP_PUSH;
        else if (rd_stb && count != '0)     op = OP_POP;
        else                                op = OP_IDLE;
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  count_nxt = load_count;
            OP_FLUSH: count_nxt = '0;
            OP_PUSH:  count_nxt = count + 1'b1;
            OP_POP:   count_nxt = count - 1'b1;
            default:  count_nxt = count;
        endcase
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (op == OP_LOAD)      state_nxt = load_target;
                else if (op == OP_PUSH) state_nxt = (DEPTH == 1) ? ST_FULL : ST_PART;
            end
            ST_PART: begin
                if (op == OP_LOAD)       state_nxt = load_target;
                else if (op == OP_FLUSH) state_nxt = ST_EMPTY;
                else if (op == OP_PUSH)  state_nxt = (count == CNT_MAX - 1'b1) ? ST_FULL : ST_PART;
                else if (op == OP_POP)   state_nxt = (count == CNTW'(1)) ? ST_EMPTY : ST_PART;
            end
            ST_FULL: begin
                if (op == OP_LOAD)       state_nxt = load_target;
                else if (op == OP_FLUSH) state_nxt = ST_EMPTY;
                else if (op == OP_POP)   state_nxt = (DEPTH == 1) ? ST_EMPTY : ST_PART;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    // outputs
    always_comb begin
        has_data = 1'b0;
        full     = 1'b0;
        unique case (state)
            ST_EMPTY: ;
            ST_PART:  has_data = 1'b1;
            ST_FULL: begin
                has_data = 1'b1;
                full     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_mdata_buffer_store.sv
module i2c_mdata_buffer_store
    import i2c_mdata_buffer_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  buf_op_e                op,
    input  logic [CNTW-1:0]        count,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [CNTW-1:0]        load_count,
    input  logic [DEPTH*WIDTH-1:0] load_data,
    output logic [WIDTH-1:0]       head
);
    logic [WIDTH-1:0] ent [DEPTH];
    logic [WIDTH-1:0] above [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == DEPTH - 1) begin : g_top
            assign above[g] = '0;
        end else begin : g_mid
            assign above[g] = ent[g+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else begin
                unique case (op)
                    OP_FLUSH: ent[g] <= '0;
                    OP_LOAD:  if (CNTW'(g) < load_count) ent[g] <= load_data[g*WIDTH +: WIDTH];
                    OP_PUSH:  if (count == CNTW'(g)) ent[g] <= wr_data;
                    OP_POP:   ent[g] <= above[g];
                    default:  ;
                endcase
            end
        end
    end

    assign head = ent[0];
endmodule

// File: rtl/i2c_mdata_buffer.sv
module i2c_mdata_buffer
    import i2c_mdata_buffer_pkg::*;
#(
    parameter int              DEPTH         = 4,
    parameter int              WIDTH         = 8,
    parameter logic [WIDTH-1:0] EMPTY_PATTERN = '1,
    localparam int             CNTW          = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic                   rd_stb,
    output logic [WIDTH-1:0]       rd_data,
    input  logic                   flush,
    input  logic                   load_stb,
    input  logic [CNTW-1:0]        load_count,
    input  logic [DEPTH*WIDTH-1:0] load_data,
    output logic                   has_data,
    output logic                   full
);
    buf_op_e          op;
    logic [CNTW-1:0]  count;
    logic [WIDTH-1:0] head;

    i2c_mdata_buffer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .flush      (flush),
        .load_stb   (load_stb),
        .load_count (load_count),
        .op         (op),
        .count      (count),
        .has_data   (has_data),
        .full       (full)
    );

    i2c_mdata_buffer_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .count      (count),
        .wr_data    (wr_data),
        .load_count (load_count),
        .load_data  (load_data),
        .head       (head)
    );

    assign rd_data = has_data ? head : EMPTY_PATTERN;
endmodule

// File: rtl/i2c_mdata_buffer_chk.sv
module i2c_mdata_buffer_chk #(
    parameter int               DEPTH         = 4,
    parameter int               WIDTH         = 8,
    parameter logic [WIDTH-1:0] EMPTY_PATTERN = '1,
    localparam int              CNTW          = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_stb,
    input logic                   rd_stb,
    input logic                   flush,
    input logic                   load_stb,
    input logic [CNTW-1:0]        load_count,
    input logic [DEPTH*WIDTH-1:0] load_data,
    input logic [WIDTH-1:0]       rd_data,
    input logic                   has_data,
    input logic                   full
);
    logic ld;
    assign ld = load_stb && (load_count != '0) && (load_count <= CNTW'(DEPTH));

    p_full_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> has_data);

    p_empty_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !has_data |-> rd_data == EMPTY_PATTERN);

    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_stb && !rd_stb && !ld && !flush) |=> (full && $stable(rd_data)));

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !ld) |=> (!has_data && !full));

    p_load_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && load_count == CNTW'(DEPTH)) |=> full);

    p_load_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (has_data && rd_data == $past(load_data[WIDTH-1:0])));

    p_bad_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !ld && !flush && !wr_stb && !rd_stb)
        |=> ($stable(has_data) && $stable(full) && $stable(rd_data)));

    if (DEPTH > 1) begin : g_pop_full
        p_pop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (full && rd_stb && !wr_stb && !ld && !flush) |=> (!full && has_data));
    end
endmodule

bind i2c_mdata_buffer i2c_mdata_buffer_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .EMPTY_PATTERN(EMPTY_PATTERN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .flush      (flush),
    .load_stb   (load_stb),
    .load_count (load_count),
    .load_data  (load_data),
    .rd_data    (rd_data),
    .has_data   (has_data),
    .full       (full)
);

// File: tb/i2c_mdata_buffer_tb.sv
module i2c_mdata_buffer_tb;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_stb = 1'b0;
    logic [WIDTH-1:0]       wr_data = '0;
    logic                   rd_stb = 1'b0;
    logic [WIDTH-1:0]       rd_data;
    logic                   flush = 1'b0;
    logic                   load_stb = 1'b0;
    logic [CNTW-1:0]        load_count = '0;
    logic [DEPTH*WIDTH-1:0] load_data = '0;
    logic                   has_data;
    logic                   full;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    i2c_mdata_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .flush(flush),
        .load_stb(load_stb), .load_count(load_count), .load_data(load_data),
        .has_data(has_data), .full(full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic flags(input string tag, input logic hd, input logic fl);
        chk({tag, " has_data"}, 32'(has_data), 32'(hd));
        chk({tag, " full"}, 32'(full), 32'(fl));
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; wr_data = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic pop(input string tag, input logic [7:0] exp);
        @(negedge clk); rd_stb = 1'b1;
        #1 chk(tag, 32'(rd_data), 32'(exp));
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic load(input logic [CNTW-1:0] n, input logic [DEPTH*WIDTH-1:0] d);
        @(negedge clk); load_stb = 1'b1; load_count = n; load_data = d;
        @(negedge clk); load_stb = 1'b0;
    endtask

    task automatic t_reset();
        flags("R1 reset", 1'b0, 1'b0);
        chk("R1 reset rd_data", 32'(rd_data), 32'hFF);
    endtask

    task automatic t_order();
        push(8'hA1);
        flags("R4 first push", 1'b1, 1'b0);
        push(8'hB2);
        pop("R2 first byte", 8'hA1);
        flags("R6 one left", 1'b1, 1'b0);
        pop("R2 second byte", 8'hB2);
        flags("R6 last read", 1'b0, 1'b0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h30 + i));
            flags("R4 filling", 1'b1, i == DEPTH - 1);
        end
        push(8'hEE);
        flags("R3 dropped write", 1'b1, 1'b1);
        pop("R3 R6 head after drop", 8'h30);
        flags("R6 read from full", 1'b1, 1'b0);
        for (int i = 1; i < DEPTH; i++) pop("R3 R6 shifted byte", 8'(8'h30 + i));
        flags("R6 drained", 1'b0, 1'b0);
        chk("R3 no stray byte", 32'(rd_data), 32'hFF);
    endtask

    task automatic t_empty_read();
        pop("R5 empty read", 8'hFF);
        flags("R5 empty read state", 1'b0, 1'b0);
        push(8'h5C);
        pop("R5 after empty read", 8'h5C);
        flags("R5 drained", 1'b0, 1'b0);
    endtask

    task automatic t_flush();
        push(8'h11); push(8'h22); push(8'h33);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        flags("R7 flush", 1'b0, 1'b0);
        chk("R7 flush rd_data", 32'(rd_data), 32'hFF);
        push(8'h44);
        @(negedge clk); flush = 1'b1; wr_stb = 1'b1; wr_data = 8'h55;
        @(negedge clk); flush = 1'b0; wr_stb = 1'b0;
        flags("R7 flush beats write", 1'b0, 1'b0);
        push(8'h66);
        pop("R7 byte after flush", 8'h66);
    endtask

    task automatic t_load();
        for (int n = 1; n <= DEPTH; n++) begin
            logic [DEPTH*WIDTH-1:0] d;
            for (int i = 0; i < DEPTH; i++) d[i*WIDTH +: WIDTH] = 8'(8'h10 * n + i);
            load(CNTW'(n), d);
            flags("R8 after load", 1'b1, n == DEPTH);
            for (int i = 0; i < n; i++) pop("R8 loaded byte", 8'(8'h10 * n + i));
            flags("R8 load drained", 1'b0, 1'b0);
        end
    endtask

    task automatic t_collide();
        push(8'h99);
        @(negedge clk);
        load_stb = 1'b1; load_count = CNTW'(2); load_data = {16'h0, 8'hC2, 8'hC1};
        wr_stb = 1'b1; wr_data = 8'h77;
        @(negedge clk); load_stb = 1'b0; wr_stb = 1'b0;
        pop("R9 load wins byte0", 8'hC1);
        pop("R9 load wins byte1", 8'hC2);
        flags("R9 no host byte", 1'b0, 1'b0);
        @(negedge clk);
        load_stb = 1'b1; load_count = CNTW'(1); load_data = {24'h0, 8'hD1};
        flush = 1'b1; rd_stb = 1'b1;
        @(negedge clk); load_stb = 1'b0; flush = 1'b0; rd_stb = 1'b0;
        flags("R9 load beats flush and read", 1'b1, 1'b0);
        pop("R9 loaded byte kept", 8'hD1);
    endtask

    task automatic t_bad_load();
        load(CNTW'(0), {8'h01, 8'h02, 8'h03, 8'h04});
        flags("R10 count zero", 1'b0, 1'b0);
        push(8'h3A);
        load(CNTW'(5), {8'h01, 8'h02, 8'h03, 8'h04});
        flags("R10 count too big", 1'b1, 1'b0);
        pop("R10 contents kept", 8'h3A);
        flags("R10 drained", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_order();
        t_full();
        t_empty_read();
        t_flush();
        t_load();
        t_collide();
        t_bad_load();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule